// File: doc/BRIEF.md
# I2S Master Transmitter with Bit-Clock and Word-Select Generation

This block is a serial audio transmitter that acts as the clock master of its link. It divides the system clock down to a bit clock, generates the word-select clock, and shifts out one left and one right sample per frame. It has up to four stereo pairs, and each pair has its own serial data line. Samples arrive in parallel from an upstream FIFO through one valid/ready handshake per pair. Each sample is right-justified in its lane.

A slot-length code sets how many bit-clock cycles each half-frame lasts. This is independent of each pair's sample resolution. A shorter sample is padded with zeros to the end of its slot. A longer sample is cut to the slot length.

The enables are layered. The clocks run only while the global, transmitter and clock enables are all high. Each pair also has its own enable. A pair with no sample ready at the start of a slot sends silence and reports an underrun.

Top module: `i2stx_top`

## Requirements
- R1: While reset is held, or while any one of `glb_en`, `tx_en` and `clk_en` is low, the block holds these idle values: `sck` low, `ws` high, every `sd` bit low, no `smp_ready` and no `underrun`.
- R2: While running, `sck` toggles once every `div_half`+1 system clock cycles, so its period is 2·(`div_half`+1) cycles.
- R3: `slot_cfg[4:3]` selects the slot length: 00 gives 16 bit clocks, 01 gives 24 and 10 gives 32; 11 behaves like 00. `ws` changes only on a falling edge of `sck`, once per slot.
- R4: `ws` low marks the left slot and `ws` high marks the right slot. The first slot after the clocks start is a left slot. Each enabled pair takes one sample per slot, so its samples alternate left, right, left, and so on.
- R5: Data goes out MSB first, on falling edges of `sck`. The MSB appears one bit clock after the `ws` transition that opens its slot. The sample's final slot bit falls in the first bit clock of the next slot.
- R6: The pair resolution code in `res_cfg[3p+2:3p]` selects 2 for 16 bits, 4 for 24 bits and 5 for 32 bits; any other code means 16. The sample is taken from the low bits of its lane. Slot bits after the sample are driven as zero.
- R7: When the resolution exceeds the slot length, only the top slot-length bits of the sample are sent.
- R8: For an enabled pair, `smp_ready` is high for one system cycle at the start of each slot. The sample is taken in that cycle when `smp_valid` is also high.
- R9: When `smp_valid` is low at the start of a slot, that slot is sent as all zeros and `underrun` pulses high for exactly one cycle.
- R10: A pair whose `pair_en` bit is low never raises `smp_ready` or `underrun`, and its `sd` stays low.
- R11: Dropping any of the three enables stops the clocks on the next cycle. A later restart begins again with a fresh left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmitter block enable |
| clk_en | input | 1 | Serial clock generation enable |
| pair_en | input | NPAIR | Per-pair enable |
| slot_cfg | input | 5 | Slot-length code (bits 4:3 decoded) |
| res_cfg | input | 3·NPAIR | Per-pair resolution codes, pair p at bits 3p+2:3p |
| div_half | input | DIVW | Bit-clock half period minus one, in system cycles |
| smp_valid | input | NPAIR | Sample valid per pair |
| smp_data | input | SW·NPAIR | Right-justified sample per pair, pair p at bits SW·p+SW-1:SW·p |
| smp_ready | output | NPAIR | Sample accepted this cycle, per pair |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select (low = left) |
| sd | output | NPAIR | Serial data line per pair |
| underrun | output | NPAIR | One-cycle pulse: slot began with no sample |

## Verification
The assertions assume two things about the inputs. First, the slot code, the resolution codes and the divider do not change while the clocks run. Second, the enables go to zero before any reconfiguration. The stimulus keeps within this: it changes configuration only after it has dropped one of the three enables. The upstream model may lower `smp_valid` at any point inside a slot, and the bench does this deliberately to provoke underruns. A receiver model in the bench samples `sd` on rising edges of `sck`. It rebuilds each word from one `ws` transition to the next and compares it with the sample that the handshake or an underrun pulse queued for that pair.

// File: rtl/i2stx_pkg.sv
`timescale 1ns/1ps
package i2stx_pkg;

    localparam int MAX_SLOT = 32;
    localparam int POS_W    = $clog2(MAX_SLOT);

    // events produced by the bit-clock generator for the data lanes
    typedef struct packed {
        logic fall;   // bit clock falls at the end of this cycle
        logic start;  // that falling edge also opens a new slot
    } bclk_evt_t;

    function automatic int slot_bits(input logic [4:0] code);
        case (code[4:3])
            2'b01:   return 24;
            2'b10:   return 32;
            default: return 16;
        endcase
    endfunction

    function automatic int res_bits(input logic [2:0] code);
        case (code)
            3'd4:    return 24;
            3'd5:    return 32;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/i2stx_clkgen.sv
`timescale 1ns/1ps
module i2stx_clkgen
    import i2stx_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div_half,
    input  logic [5:0]      slot_len,
    output logic            sck,
    output logic            ws,
    output bclk_evt_t       evt
);

    typedef struct packed {
        logic [DIVW-1:0]  div;
        logic             sck;
        logic             ws;
        logic [POS_W-1:0] pos;
        logic             fresh;
    } clk_st_t;

    localparam clk_st_t IDLE_ST = '{div: '0, sck: 1'b0, ws: 1'b1, pos: '0, fresh: 1'b1};

    clk_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d      = st_q;
        tick      = run && (st_q.div == div_half);
        evt.fall  = tick && st_q.sck;
        evt.start = evt.fall && (st_q.fresh || ({1'b0, st_q.pos} == slot_len - 6'd1));
        if (!run) begin
            st_d = IDLE_ST;
        end else begin
            st_d.div = tick ? '0 : st_q.div + 1'b1;
            if (tick) st_d.sck = ~st_q.sck;
            if (evt.start) begin
                st_d.pos   = '0;
                st_d.ws    = ~st_q.ws;
                st_d.fresh = 1'b0;
            end else if (evt.fall) begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE_ST;
        else        st_q <= st_d;
    end

    assign sck = st_q.sck;
    assign ws  = st_q.ws;

    AST_CLOCKS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!st_q.sck && st_q.ws)); // R11

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(st_q.ws)) |-> $fell(st_q.sck)); // R3

endmodule

// File: rtl/i2stx_lane.sv
`timescale 1ns/1ps
module i2stx_lane
    import i2stx_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  bclk_evt_t     evt,
    input  logic          en,
    input  logic [2:0]    res_code,
    input  logic [5:0]    slot_len,
    input  logic          valid,
    input  logic [SW-1:0] data,
    output logic          ready,
    output logic          sd,
    output logic          underrun
);

    typedef struct packed {
        logic [SW-1:0] sh;
        logic          sd;
        logic          und;
    } lane_st_t;

    lane_st_t      ln_d, ln_q;
    int            res_w, eff_w;
    logic [SW-1:0] aligned;

    always_comb begin
        res_w   = res_bits(res_code);
        eff_w   = (res_w < int'(slot_len)) ? res_w : int'(slot_len);
        // MSB of the sample to the top, keep only the bits that fit the slot
        aligned = (data << (SW - res_w)) & ~({SW{1'b1}} >> eff_w);
        ready   = evt.start && en;

        ln_d     = ln_q;
        ln_d.und = 1'b0;
        if (!run) begin
            ln_d = '0;
        end else if (evt.fall) begin
            ln_d.sd = ln_q.sh[SW-1];
            ln_d.sh = ln_q.sh << 1;
            if (evt.start) begin
                ln_d.sh  = (en && valid) ? aligned : '0;
                ln_d.und = en && !valid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign sd       = ln_q.sd;
    assign underrun = ln_q.und;

    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> en); // R10

    AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.und |=> !ln_q.und); // R9

    AST_TAKEN_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && valid) |=> !ln_q.und); // R8

endmodule

// File: rtl/i2stx_top.sv
`timescale 1ns/1ps
module i2stx_top
    import i2stx_pkg::*;
#(
    parameter int NPAIR = 4,
    parameter int SW    = 32,
    parameter int DIVW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                glb_en,
    input  logic                tx_en,
    input  logic                clk_en,
    input  logic [NPAIR-1:0]    pair_en,
    input  logic [4:0]          slot_cfg,
    input  logic [3*NPAIR-1:0]  res_cfg,
    input  logic [DIVW-1:0]     div_half,
    input  logic [NPAIR-1:0]    smp_valid,
    input  logic [SW*NPAIR-1:0] smp_data,
    output logic [NPAIR-1:0]    smp_ready,
    output logic                sck,
    output logic                ws,
    output logic [NPAIR-1:0]    sd,
    output logic [NPAIR-1:0]    underrun
);

    logic      run;
    logic [5:0] slot_len;
    bclk_evt_t evt;

    assign run      = glb_en && tx_en && clk_en;
    assign slot_len = 6'(slot_bits(slot_cfg));

    i2stx_clkgen #(.DIVW(DIVW)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_half (div_half),
        .slot_len (slot_len),
        .sck      (sck),
        .ws       (ws),
        .evt      (evt)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_lane
        i2stx_lane #(.SW(SW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .evt      (evt),
            .en       (pair_en[p]),
            .res_code (res_cfg[3*p +: 3]),
            .slot_len (slot_len),
            .valid    (smp_valid[p]),
            .data     (smp_data[SW*p +: SW]),
            .ready    (smp_ready[p]),
            .sd       (sd[p]),
            .underrun (underrun[p])
        );
    end

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> ($stable(slot_cfg) && $stable(res_cfg) && $stable(div_half))); // R3

endmodule

// File: tb/sim_i2stx_top.sv
`timescale 1ns/1ps
module sim_i2stx_top;

    localparam int NP   = 4;
    localparam int SW   = 32;
    localparam int DIVW = 8;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                glb_en, tx_en, clk_en;
    logic [NP-1:0]       pair_en;
    logic [4:0]          slot_cfg;
    logic [3*NP-1:0]     res_cfg;
    logic [DIVW-1:0]     div_half;
    logic [NP-1:0]       smp_valid;
    logic [SW*NP-1:0]    smp_data;
    logic [NP-1:0]       smp_ready;
    logic                sck, ws;
    logic [NP-1:0]       sd;
    logic [NP-1:0]       underrun;

    always #4 clk = ~clk;

    i2stx_top #(.NPAIR(NP), .SW(SW), .DIVW(DIVW)) u0 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tx_en(tx_en), .clk_en(clk_en),
        .pair_en(pair_en), .slot_cfg(slot_cfg), .res_cfg(res_cfg), .div_half(div_half),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
    );

    typedef struct { bit ch; logic [31:0] w; } item_t;

    int          nvec = 0;
    int          nfail = 0;
    item_t       sbq [NP][$];
    int unsigned idx [NP];
    bit [NP-1:0] stall;
    int          und_cnt [NP];
    int          ncmp [NP];
    bit [NP-1:0] quiet_bad;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int res_of(input logic [2:0] c);
        if (c == 3'd4) return 24;
        if (c == 3'd5) return 32;
        return 16;
    endfunction

    function automatic int slot_of(input logic [4:0] c);
        if (c[4:3] == 2'b01) return 24;
        if (c[4:3] == 2'b10) return 32;
        return 16;
    endfunction

    // R6 R7: top min(res,slot) sample bits, zero padded to the slot length
    function automatic logic [31:0] exp_word(input logic [31:0] d, input logic [2:0] rc, input logic [4:0] sc);
        int r = res_of(rc);
        int s = slot_of(sc);
        int e = (r < s) ? r : s;
        longint unsigned v = longint'(d) & ((64'd1 << r) - 1);
        v = v >> (r - e);
        v = v << (s - e);
        return v[31:0];
    endfunction

    function automatic logic [31:0] pattern(input int p, input int unsigned i);
        return (i * 32'h9E37_79B9) ^ (32'h5A00_00C3 << p) ^ i;
    endfunction

    // driver: feeds samples, pushes expected words at handshake or underrun
    initial begin
        bit [NP-1:0] take;
        for (int p = 0; p < NP; p++) begin
            idx[p] = 0;
            und_cnt[p] = 0;
        end
        smp_valid = '0;
        for (int p = 0; p < NP; p++) smp_data[SW*p +: SW] = pattern(p, 0);
        forever begin
            @(negedge clk);
            take = '0;
            for (int p = 0; p < NP; p++) begin
                if (smp_ready[p] && smp_valid[p]) begin
                    sbq[p].push_back('{~ws, exp_word(smp_data[SW*p +: SW], res_cfg[3*p +: 3], slot_cfg)});
                    take[p] = 1'b1;
                end
                if (underrun[p]) begin
                    sbq[p].push_back('{ws, 32'd0});   // R9 silent slot
                    und_cnt[p]++;
                end
                if (!pair_en[p] && (smp_ready[p] || sd[p])) quiet_bad[p] = 1'b1;
            end
            @(posedge clk);
            #1;
            for (int p = 0; p < NP; p++) begin
                if (take[p]) idx[p]++;
                smp_data[SW*p +: SW] = pattern(p, idx[p]);
                smp_valid[p] = !stall[p];
            end
        end
    end

    // monitor: receiver model sampling sd on rising sck
    initial begin
        bit     sck_p, ws_p, have_rise, ws_seen;
        int     since, rslot;
        longint unsigned acc [NP];
        int     cnt [NP];
        item_t  it;
        sck_p = 0; ws_p = 1; have_rise = 0; ws_seen = 0; since = 0; rslot = 0;
        for (int p = 0; p < NP; p++) begin acc[p] = 0; cnt[p] = 0; ncmp[p] = 0; end
        forever begin
            @(negedge clk);
            if (!(glb_en && tx_en && clk_en)) begin
                sck_p = 0; ws_p = 1; have_rise = 0; ws_seen = 0; since = 0; rslot = 0;
                for (int p = 0; p < NP; p++) begin acc[p] = 0; cnt[p] = 0; end
            end else begin
                since++;
                if (sck && !sck_p) begin
                    if (have_rise)
                        chk(since == 2 * (int'(div_half) + 1), "R2 bit clock period", since, 2 * (int'(div_half) + 1));
                    have_rise = 1;
                    since = 0;
                    for (int p = 0; p < NP; p++) begin
                        acc[p] = (acc[p] << 1) | longint'(sd[p]);
                        cnt[p]++;
                    end
                    if (ws != ws_p) begin
                        if (ws_seen) chk(rslot == slot_of(slot_cfg), "R3 bit clocks per slot", rslot, slot_of(slot_cfg));
                        ws_seen = 1;
                        rslot = 1;
                        for (int p = 0; p < NP; p++) begin
                            if (cnt[p] == slot_of(slot_cfg) && pair_en[p]) begin
                                if (sbq[p].size() == 0) begin
                                    chk(0, "R8 word with no queued sample", acc[p], 0);
                                end else begin
                                    it = sbq[p].pop_front();
                                    ncmp[p]++;
                                    chk(it.ch == ws_p, "R4 slot channel", ws_p, it.ch);
                                    chk(acc[p][31:0] == it.w, "R5 serial word", acc[p][31:0], it.w);
                                end
                            end
                            acc[p] = 0;
                            cnt[p] = 0;
                        end
                    end else begin
                        rslot++;
                    end
                    ws_p = ws;
                end
                sck_p = sck;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    task automatic flush();
        for (int p = 0; p < NP; p++) begin
            sbq[p].delete();
            und_cnt[p] = 0;
            ncmp[p] = 0;
        end
        quiet_bad = '0;
    endtask

    task automatic check_stopped(input string tag);
        repeat (2) @(negedge clk);
        chk(sck == 1'b0, {tag, " sck halted"}, sck, 0);
        chk(ws == 1'b1, {tag, " ws idle high"}, ws, 1);
        repeat (3) @(posedge clk);
        #1 flush();
    endtask

    initial begin
        bit seen;
        rst_n = 0; glb_en = 0; tx_en = 0; clk_en = 0;
        pair_en = '0; slot_cfg = 5'h10; res_cfg = '0; div_half = 8'd1;
        stall = '0; quiet_bad = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        @(negedge clk);
        chk(sck == 0, "R1 sck after reset", sck, 0);
        chk(ws == 1, "R1 ws after reset", ws, 1);
        chk(sd == '0, "R1 sd after reset", sd, 0);
        chk(smp_ready == '0, "R1 ready after reset", smp_ready, 0);
        chk(underrun == '0, "R1 underrun after reset", underrun, 0);

        // R1 clock enable still low: nothing moves
        @(posedge clk); #1;
        glb_en = 1; tx_en = 1; pair_en = 4'b0111;
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (sck || sd != '0 || smp_ready != '0) seen = 1;
        end
        chk(!seen, "R1 idle without clock enable", seen, 0);

        // run A: 32-bit slots, resolutions 32/24/16, pair 3 disabled (R10)
        @(posedge clk); #1;
        res_cfg = {3'd2, 3'd2, 3'd4, 3'd5};
        slot_cfg = 5'h10; div_half = 8'd1;
        clk_en = 1;
        repeat (2200) @(posedge clk);
        #1;
        chk(ncmp[0] >= 6, "R8 pair0 samples consumed", ncmp[0], 6);
        chk(ncmp[2] >= 6, "R6 pair2 16-bit words compared", ncmp[2], 6);
        chk(und_cnt[0] == 0 && und_cnt[1] == 0, "R9 no underrun while fed", und_cnt[0] + und_cnt[1], 0);
        chk(quiet_bad[3] == 0, "R10 disabled pair silent", quiet_bad[3], 0);
        clk_en = 0;
        check_stopped("R11 clock enable drop");

        // run B: 16-bit slots, resolutions longer than slot (R7), underrun on pair 1
        res_cfg = {3'd2, 3'd4, 3'd2, 3'd5};
        slot_cfg = 5'h00; div_half = 8'd2; pair_en = 4'b1111;
        clk_en = 1;
        repeat (1500) @(posedge clk);
        #1 stall[1] = 1;
        repeat (1200) @(posedge clk);
        #1 stall[1] = 0;
        repeat (1000) @(posedge clk);
        #1;
        chk(und_cnt[1] >= 2, "R9 underruns while starved", und_cnt[1], 2);
        chk(und_cnt[0] == 0, "R9 no underrun on fed pair", und_cnt[0], 0);
        chk(ncmp[0] >= 6, "R7 truncated words compared", ncmp[0], 6);
        glb_en = 0;
        check_stopped("R11 global enable drop");

        // run C: 24-bit slots, unknown resolution code on pair 3 (R6)
        glb_en = 1;
        res_cfg = {3'd0, 3'd4, 3'd2, 3'd5};
        slot_cfg = 5'h08; div_half = 8'd0;
        clk_en = 1;
        repeat (1500) @(posedge clk);
        #1;
        chk(ncmp[3] >= 6, "R6 default resolution words compared", ncmp[3], 6);
        chk(ncmp[1] >= 6, "R4 restart left-first words compared", ncmp[1], 6);
        tx_en = 0;
        check_stopped("R11 transmitter enable drop");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule